// File: doc/BRIEF.md
# Multimode Counter and Shift Register

This block holds a small register that can act as a modulo-2^WIDTH up/down counter, a bidirectional shift register, a parallel-load latch, a synchronous clear, a bitwise inverter or a plain holding register. A 3-bit operation select is sampled on every rising clock edge and picks what happens to the register on that edge. Two active-low count enables gate counting. One of them, `cet_sin`, is also the serial input for upward shifts. `sin_hi` is the serial input for downward shifts.

A single status output, `tc_n`, serves two uses. In the counting operations it is an active-low terminal count. In the shift operations it carries the top register bit. Wiring one stage's `tc_n` to the next stage's `cet_sin` therefore chains stages for wide counters and for long upward shifts with one wire per link. An asynchronous active-high master clear overrides everything else. A synchronous active-low reset also clears the register on a clock edge.

Top module: `mode_cnt_shreg`

## Requirements
- R1: While `mreset` is 1, `q` is 0 at once, without waiting for a clock edge, and stays 0 whatever the other inputs do. A clock edge with `rst_n` = 0 also sets `q` to 0.
- R2: With `sel` = 3'b110 (count up) and both `cep_n` and `cet_sin` at 0, `q` becomes `q`+1 on the edge, and the maximum value wraps to 0.
- R3: With `sel` = 3'b100 (count down) and both enables at 0, `q` becomes `q`-1 on the edge, and 0 wraps to the maximum value.
- R4: In either count operation, if `cep_n` or `cet_sin` is 1, `q` keeps its value.
- R5: With `sel` = 3'b011 (shift up), `q` becomes {`q`[WIDTH-2:0], `cet_sin`}. Bit 0 takes the serial input and each bit moves one place toward the top.
- R6: With `sel` = 3'b010 (shift down), `q` becomes {`sin_hi`, `q`[WIDTH-1:1]}. The top bit takes `sin_hi`.
- R7: With `sel` = 3'b000, `q` loads `preset`.
- R8: With `sel` = 3'b001, every bit of `q` is inverted.
- R9: With `sel` = 3'b101, `q` becomes 0 on the edge.
- R10: With `sel` = 3'b111, `q` keeps its value.
- R11: In count up, `tc_n` is 0 exactly when `q` is all ones and `cet_sin` is 0. In count down, `tc_n` is 0 exactly when `q` is 0 and `cet_sin` is 0. Otherwise `tc_n` is 1 in these operations. `cep_n` has no effect on `tc_n`.
- R12: In both shift operations `tc_n` equals `q`[WIDTH-1]. In load, invert, clear and hold, `tc_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mreset | input | 1 | Asynchronous master clear, active high |
| sel | input | 3 | Operation select |
| cep_n | input | 1 | Count enable, active low |
| cet_sin | input | 1 | Count enable (active low) and serial input for shift up |
| sin_hi | input | 1 | Serial input for shift down |
| preset | input | WIDTH | Parallel load value |
| q | output | WIDTH | Register contents |
| tc_n | output | 1 | Terminal count (active low) in count operations, top bit in shift operations |

## Verification
The bench builds the block with its default WIDTH of 4. At that size every one of the eight operations can be applied from all sixteen starting values under all four enable combinations, with the serial inputs varied. This covers both wrap points and every `tc_n` case. Two more 4-bit instances are chained through `tc_n` to `cet_sin`. They check the carry ripple of an 8-bit counter over more than a full cycle, and the bit handover of an 8-bit upward shift. The master clear is also checked between clock edges and across an edge that requests a load.

// File: rtl/mcsr_pkg.sv
// Shared operation encoding for the multimode counter/shift register.
// Assumes a 3-bit select sampled at the rising clock edge.
package mcsr_pkg;
    typedef enum logic [2:0] {
        OP_LOAD   = 3'b000,
        OP_INVERT = 3'b001,
        OP_SHDN   = 3'b010,
        OP_SHUP   = 3'b011,
        OP_DOWN   = 3'b100,
        OP_CLEAR  = 3'b101,
        OP_UP     = 3'b110,
        OP_KEEP   = 3'b111
    } op_e;
endpackage

// File: rtl/mcsr_next.sv
// Next-state logic: computes the register value after one edge for the
// selected operation. Assumes WIDTH >= 1; for WIDTH == 1 a shift simply
// takes the serial bit.
module mcsr_next
    import mcsr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  op_e              op,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] preset,
    input  logic             cep_n,
    input  logic             cet_sin,
    input  logic             sin_hi,
    output logic [WIDTH-1:0] nxt
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] shift_up_v;
    logic [WIDTH-1:0] shift_dn_v;
    logic             cnt_go;

    // Shift paths; the narrow variant has no bits to move.
    generate
        if (WIDTH > 1) begin : g_wide
            assign shift_up_v = {cur[WIDTH-2:0], cet_sin};
            assign shift_dn_v = {sin_hi, cur[WIDTH-1:1]};
        end else begin : g_narrow
            assign shift_up_v = cet_sin;
            assign shift_dn_v = sin_hi;
        end
    endgenerate

    // Counting needs both active-low enables asserted.
    assign cnt_go = ~cep_n & ~cet_sin;

    // Select the next value for the requested operation.
    always_comb begin
        unique case (op)
            OP_LOAD:   nxt = preset;
            OP_INVERT: nxt = ~cur;
            OP_SHDN:   nxt = shift_dn_v;
            OP_SHUP:   nxt = shift_up_v;
            OP_DOWN:   nxt = cnt_go ? cur - ONE : cur;
            OP_CLEAR:  nxt = '0;
            OP_UP:     nxt = cnt_go ? cur + ONE : cur;
            default:   nxt = cur;
        endcase
    end
endmodule

// File: rtl/mcsr_tc.sv
// Terminal-count / top-bit output. Active-low terminal count in the count
// operations (gated by the trickle enable), top register bit in the shift
// operations, inactive (1) otherwise. Purely combinational.
module mcsr_tc
    import mcsr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  op_e              op,
    input  logic [WIDTH-1:0] cur,
    input  logic             cet_sin,
    output logic             tc_n
);
    logic at_max;
    logic at_min;

    assign at_max = &cur;
    assign at_min = ~|cur;

    // Choose the meaning of the shared output for the current operation.
    always_comb begin
        unique case (op)
            OP_UP:            tc_n = ~(at_max & ~cet_sin);
            OP_DOWN:          tc_n = ~(at_min & ~cet_sin);
            OP_SHUP, OP_SHDN: tc_n = cur[WIDTH-1];
            default:          tc_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/mode_cnt_shreg.sv
// Top: multimode counter / bidirectional shift register. Holds the state
// register, applies the asynchronous master clear and the synchronous reset,
// and joins the next-state and terminal-count pieces. Assumes inputs are
// synchronous to clk and mreset is released away from a clock edge.
module mode_cnt_shreg
    import mcsr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mreset,
    input  logic [2:0]       sel,
    input  logic             cep_n,
    input  logic             cet_sin,
    input  logic             sin_hi,
    input  logic [WIDTH-1:0] preset,
    output logic [WIDTH-1:0] q,
    output logic             tc_n
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    op_e              op;
    logic [WIDTH-1:0] nxt;

    assign op = op_e'(sel);

    mcsr_next #(.WIDTH(WIDTH)) next_i (
        .op      (op),
        .cur     (q),
        .preset  (preset),
        .cep_n   (cep_n),
        .cet_sin (cet_sin),
        .sin_hi  (sin_hi),
        .nxt     (nxt)
    );

    mcsr_tc #(.WIDTH(WIDTH)) tc_i (
        .op      (op),
        .cur     (q),
        .cet_sin (cet_sin),
        .tc_n    (tc_n)
    );

    // State register: async master clear wins, then sync reset, then update.
    always_ff @(posedge clk or posedge mreset) begin
        if (mreset)      q <= '0;
        else if (!rst_n) q <= '0;
        else             q <= nxt;
    end

    // R1
    mclr_zero_chk: assert property (@(posedge clk) mreset |-> q == '0);

    // R1
    srst_zero_chk: assert property (@(posedge clk) disable iff (mreset)
        !rst_n |=> q == '0);

    // R2
    up_step_chk: assert property (@(posedge clk) disable iff (mreset)
        rst_n && sel == 3'b110 && !cep_n && !cet_sin |=> q == $past(q) + ONE);

    // R3
    down_step_chk: assert property (@(posedge clk) disable iff (mreset)
        rst_n && sel == 3'b100 && !cep_n && !cet_sin |=> q == $past(q) - ONE);

    // R4
    cnt_idle_chk: assert property (@(posedge clk) disable iff (mreset)
        rst_n && sel[2] && !sel[0] && (cep_n || cet_sin) |=> $stable(q));

    // R9
    clear_chk: assert property (@(posedge clk) disable iff (mreset)
        rst_n && sel == 3'b101 |=> q == '0);

    // R12
    shift_tc_chk: assert property (@(posedge clk) disable iff (mreset)
        sel[2:1] == 2'b01 |-> tc_n == q[WIDTH-1]);
endmodule

// File: tb/mode_cnt_shreg_tb_top.sv
module mode_cnt_shreg_tb_top;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n, mreset;
    logic [2:0]   sel;
    logic         cep_n, cet_sin, sin_hi;
    logic [W-1:0] preset;
    logic [W-1:0] q;
    logic         tc_n;

    int nvec = 0;
    int nerr = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    mode_cnt_shreg #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .mreset(mreset), .sel(sel),
        .cep_n(cep_n), .cet_sin(cet_sin), .sin_hi(sin_hi),
        .preset(preset), .q(q), .tc_n(tc_n)
    );

    // Two-stage cascade: low stage tc_n feeds high stage cet_sin.
    logic [2:0]   c_sel;
    logic         c_cep_n, c_cet, c_rst_n;
    logic [W-1:0] lo_q, hi_q;
    logic         lo_tc, hi_tc;

    mode_cnt_shreg #(.WIDTH(W)) cas_lo (
        .clk(clk), .rst_n(c_rst_n), .mreset(1'b0), .sel(c_sel),
        .cep_n(c_cep_n), .cet_sin(c_cet), .sin_hi(1'b0),
        .preset('0), .q(lo_q), .tc_n(lo_tc)
    );
    mode_cnt_shreg #(.WIDTH(W)) cas_hi (
        .clk(clk), .rst_n(c_rst_n), .mreset(1'b0), .sel(c_sel),
        .cep_n(c_cep_n), .cet_sin(lo_tc), .sin_hi(1'b0),
        .preset('0), .q(hi_q), .tc_n(hi_tc)
    );

    task automatic check(input string tag, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] model_next(input logic [2:0] s,
        input logic [W-1:0] c, input logic ep, input logic et,
        input logic d3, input logic [W-1:0] p);
        case (s)
            3'b000: return p;
            3'b001: return ~c;
            3'b010: return {d3, c[W-1:1]};
            3'b011: return {c[W-2:0], et};
            3'b100: return (!ep && !et) ? W'((int'(c) + 15) % 16) : c;
            3'b101: return '0;
            3'b110: return (!ep && !et) ? W'((int'(c) + 1) % 16) : c;
            default: return c;
        endcase
    endfunction

    function automatic logic model_tc(input logic [2:0] s,
        input logic [W-1:0] c, input logic et);
        case (s)
            3'b110: return !(c == 15 && !et);
            3'b100: return !(c == 0 && !et);
            3'b010, 3'b011: return c[W-1];
            default: return 1'b1;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] s, input logic ep,
        input logic et);
        case (s)
            3'b000: return "R7";
            3'b001: return "R8";
            3'b010: return "R6";
            3'b011: return "R5";
            3'b101: return "R9";
            3'b111: return "R10";
            3'b110: return (!ep && !et) ? "R2" : "R4";
            default: return (!ep && !et) ? "R3" : "R4";
        endcase
    endfunction

    initial begin
        #(4 * 200000);
        if (!finished) begin
            nvec++;
            nerr++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] exp_q;
        logic [7:0]   sh;
        rst_n = 1'b0; mreset = 1'b0; sel = 3'b000; cep_n = 1'b0;
        cet_sin = 1'b0; sin_hi = 1'b0; preset = 4'd11;
        c_rst_n = 1'b0; c_sel = 3'b000; c_cep_n = 1'b0; c_cet = 1'b0;
        @(posedge clk); #1;
        check("R1 sync reset", int'(q), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Sweep: every operation from every state under every enable combo.
        for (int m = 0; m < 8; m++) begin
            for (int st = 0; st < 16; st++) begin
                for (int en = 0; en < 4; en++) begin
                    sel = 3'b000; preset = W'(st);
                    @(posedge clk); #1;
                    check("R7 load", int'(q), st);
                    @(negedge clk);
                    sel = 3'(m); cep_n = en[0]; cet_sin = en[1];
                    sin_hi = st[0] ^ en[0]; preset = ~W'(st);
                    #1;
                    check((m[2] && !m[0]) ? "R11 tc_n" : "R12 tc_n", int'(tc_n),
                          int'(model_tc(3'(m), W'(st), en[1])));
                    exp_q = model_next(3'(m), W'(st), en[0], en[1], sin_hi, preset);
                    @(posedge clk); #1;
                    check(req_of(3'(m), en[0], en[1]), int'(q), int'(exp_q));
                    @(negedge clk);
                end
            end
        end

        // R1: async master clear between edges, then across a load edge.
        sel = 3'b000; preset = 4'd9; cep_n = 1'b0; cet_sin = 1'b0;
        @(posedge clk); #1;
        check("R7 load before clear", int'(q), 9);
        mreset = 1'b1; #1;
        check("R1 async clear", int'(q), 0);
        @(negedge clk); preset = 4'd5;
        @(posedge clk); #1;
        check("R1 clear overrides load", int'(q), 0);
        @(negedge clk); mreset = 1'b0;
        @(posedge clk); #1;
        check("R7 load after clear", int'(q), 5);

        // Cascade counting: 8-bit up count through tc_n ripple (R2, R11).
        @(negedge clk);
        c_rst_n = 1'b1; c_sel = 3'b000;
        @(posedge clk); #1;
        @(negedge clk); c_sel = 3'b110;
        for (int k = 1; k <= 300; k++) begin
            @(posedge clk); #1;
            check("R11 cascade count", int'({hi_q, lo_q}), k % 256);
        end

        // Cascade shifting: 8-bit shift up, tc_n carries the top bit (R5, R12).
        @(negedge clk);
        c_sel = 3'b011; sh = {hi_q, lo_q};
        for (int k = 0; k < 16; k++) begin
            c_cet = k[0] ^ k[2];
            sh = {sh[6:0], c_cet};
            @(posedge clk); #1;
            check("R12 cascade shift", int'({hi_q, lo_q}), int'(sh));
            @(negedge clk);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule